// File: doc/BRIEF.md
# Pulse Period and Width Capture Timer

A 16-bit measurement timer. While running it counts count-source ticks (`cnt_en_i`). On each valid edge of the external pulse input it copies the running count into a capture register and starts a new interval. The mode field picks the valid edges. Period measurement uses one edge polarity only. Width measurement uses both edges, so consecutive captures hold alternate high and low phase lengths. Nothing records which phase a given capture holds, so software keeps track of that itself.

One interrupt request line is shared by two event sources: a capture and a counter wrap. A status flag in the mode register shows that a wrap occurred. That flag can only be cleared under a restricted rule. The first capture after a start transfers a count that has no meaning, so it raises no request. Writing a different measurement mode while the timer runs also raises a request. The pulse input is resynchronised before edge detection. Software accesses the timer through a small word-addressed register port with combinational read data.

Top module: `pulse_cap_timer`

## Requirements
- R1: After reset the mode field, the run bit (address 1, bit 0) and the wrap flag all read 0, and `irq_o` is low. While the run bit is 0, count ticks do not change the counter, pulse edges do not change the capture register (address 3), and no request is raised.
- R2: While running, the counter (address 2) increments by one on each cycle with `cnt_en_i` high. A write to address 2 loads the counter at any time, and the value reads back.
- R3: The mode field is bits [1:0] of address 0. Value 0 measures between falling edges and value 1 measures between rising edges. On each valid edge the capture register takes the count held before that edge, and the counter restarts at zero. A tick in the edge cycle is the first count of the new interval. With a tick on every cycle, the capture equals the period in cycles.
- R4: Mode value 2 treats every edge as valid. Each capture holds the length of the phase that just ended, high and low alternately. Mode value 3 has no valid edges.
- R5: `irq_o` is a one-cycle pulse, issued the cycle after each capture.
- R6: The first capture after the run bit goes from 0 to 1 still loads the capture register, but issues no request.
- R7: A tick while the counter holds all ones wraps the counter to 0, sets the wrap flag (address 0, bit 3) and issues a request.
- R8: The wrap flag clears only on a write to address 0 that meets three conditions: the timer is running, the flag is set, and at least one running tick has occurred since the flag was set. Other writes to address 0 leave the flag at 1.
- R9: Writing address 0 with a mode value different from the current one while running issues a request. Writing the same value, or any value while stopped, issues none.
- R10: A capture and a wrap in the same cycle both take effect: the capture register holds all ones and the flag is set. Exactly one request pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address (0 mode/flag, 1 run, 2 counter, 3 capture) |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data for `addr_i` |
| pulse_i | input | 1 | Asynchronous pulse to be measured |
| cnt_en_i | input | 1 | Count-source tick enable |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
The bench measures both period polarities and both width phases. A design that picks the wrong edge, or drops the tick in the edge cycle, gives a capture one count short or the wrong phase. It counts request pulses across each measurement, which exposes a design that does not suppress the first capture or that issues two pulses when a capture and a wrap coincide. It tries to clear the wrap flag with no tick since the wrap and again while stopped; a design with a loose clear rule loses the flag early. It also rewrites the mode with the same value and with a new value, both stopped and running, to catch requests that are missing or spurious.

// File: rtl/pcap_pkg.sv
`timescale 1ns/1ps
package pcap_pkg;
  typedef enum logic [1:0] {
    MODE_PER_FALL = 2'd0,
    MODE_PER_RISE = 2'd1,
    MODE_WIDTH    = 2'd2,
    MODE_RSVD     = 2'd3
  } meas_mode_e;

  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_RUN  = 2'd1;
  localparam logic [1:0] ADDR_CNT  = 2'd2;
  localparam logic [1:0] ADDR_CAP  = 2'd3;
  localparam int FLAG_POS = 3;
endpackage

// File: rtl/pcap_edge.sv
`timescale 1ns/1ps
module pcap_edge
  import pcap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pulse_i,
  input  meas_mode_e mode_i,
  output logic       valid_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic prev_q;
  logic lvl, rise, fall;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[0] <= 1'b0;
        else         sync_q[0] <= pulse_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= sync_q[g-1];
    end
  end

  assign lvl = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl;

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;

  always_comb begin
    case (mode_i)
      MODE_PER_FALL: valid_o = fall;
      MODE_PER_RISE: valid_o = rise;
      MODE_WIDTH:    valid_o = rise | fall;
      default:       valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pcap_counter.sv
`timescale 1ns/1ps
module pcap_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic         edge_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cap_o,
  output logic         cap_evt_o,
  output logic         ovf_evt_o
);
  localparam logic [W-1:0] CNT_MAX = '1;
  localparam logic [W-1:0] CNT_ONE = W'(1);

  logic [W-1:0] cnt_q, cap_q;

  assign cap_evt_o = run_i & edge_i;
  assign ovf_evt_o = run_i & tick_i & (cnt_q == CNT_MAX);

  // software load wins over capture restart
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val_i;
    else if (cap_evt_o)    cnt_q <= tick_i ? CNT_ONE : '0;
    else if (run_i && tick_i) cnt_q <= cnt_q + CNT_ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cap_q <= '0;
    else if (cap_evt_o) cap_q <= cnt_q;
  end

  assign cnt_o = cnt_q;
  assign cap_o = cap_q;
endmodule

// File: rtl/pcap_ctrl.sv
`timescale 1ns/1ps
module pcap_ctrl
  import pcap_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] addr_i,
  input  logic [1:0] wr_mode_i,
  input  logic       wr_run_i,
  input  logic       tick_i,
  input  logic       cap_evt_i,
  input  logic       ovf_evt_i,
  output meas_mode_e mode_o,
  output logic       run_o,
  output logic       flag_o,
  output logic       first_o,
  output logic       irq_o
);
  meas_mode_e mode_q;
  logic run_q, flag_q, tick_seen_q, first_q, irq_q;
  logic mode_wr, run_wr, mode_chg, cap_irq;

  assign mode_wr  = wr_en_i && (addr_i == ADDR_MODE);
  assign run_wr   = wr_en_i && (addr_i == ADDR_RUN);
  assign mode_chg = mode_wr && run_q && (meas_mode_e'(wr_mode_i) != mode_q);
  assign cap_irq  = cap_evt_i && !first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_PER_FALL;
      run_q  <= 1'b0;
    end else begin
      if (mode_wr) mode_q <= meas_mode_e'(wr_mode_i);
      if (run_wr)  run_q  <= wr_run_i;
    end
  end

  // arm first-capture suppression on each start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      first_q <= 1'b0;
    else if (run_wr && wr_run_i && !run_q) first_q <= 1'b1;
    else if (cap_evt_i)               first_q <= 1'b0;
  end

  // wrap flag: set wins; clear needs running, a tick since set, and a mode write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q      <= 1'b0;
      tick_seen_q <= 1'b0;
    end else if (ovf_evt_i) begin
      flag_q      <= 1'b1;
      tick_seen_q <= 1'b0;
    end else if (mode_wr && run_q && flag_q && tick_seen_q) begin
      flag_q      <= 1'b0;
      tick_seen_q <= 1'b0;
    end else if (flag_q && run_q && tick_i) begin
      tick_seen_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= cap_irq || ovf_evt_i || mode_chg;
  end

  assign mode_o  = mode_q;
  assign run_o   = run_q;
  assign flag_o  = flag_q;
  assign first_o = first_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/pulse_cap_timer.sv
`timescale 1ns/1ps
module pulse_cap_timer
  import pcap_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  input  logic         pulse_i,
  input  logic         cnt_en_i,
  output logic         irq_o
);
  meas_mode_e   mode;
  logic         run, flag, first_pend;
  logic         edge_valid, cap_evt, ovf_evt, cnt_load;
  logic [W-1:0] cnt, cap;

  assign cnt_load = wr_en_i && (addr_i == ADDR_CNT);

  pcap_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pulse_i (pulse_i),
    .mode_i  (mode),
    .valid_o (edge_valid)
  );

  pcap_counter #(.W(W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .tick_i     (cnt_en_i),
    .edge_i     (edge_valid),
    .load_i     (cnt_load),
    .load_val_i (wdata_i),
    .cnt_o      (cnt),
    .cap_o      (cap),
    .cap_evt_o  (cap_evt),
    .ovf_evt_o  (ovf_evt)
  );

  pcap_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wr_mode_i (wdata_i[1:0]),
    .wr_run_i  (wdata_i[0]),
    .tick_i    (cnt_en_i),
    .cap_evt_i (cap_evt),
    .ovf_evt_i (ovf_evt),
    .mode_o    (mode),
    .run_o     (run),
    .flag_o    (flag),
    .first_o   (first_pend),
    .irq_o     (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_MODE: begin
        rdata_o[1:0]     = mode;
        rdata_o[FLAG_POS] = flag;
      end
      ADDR_RUN: rdata_o[0] = run;
      ADDR_CNT: rdata_o = cnt;
      default:  rdata_o = cap;
    endcase
  end
endmodule

// File: rtl/pulse_cap_timer_chk.sv
`timescale 1ns/1ps
module pulse_cap_timer_chk
  import pcap_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         wr_en_i,
  input logic [1:0]   addr_i,
  input logic [W-1:0] wdata_i,
  input logic         tick_i,
  input logic         run_i,
  input logic         edge_i,
  input logic         first_i,
  input logic         flag_i,
  input logic [1:0]   mode_i,
  input logic [W-1:0] cnt_i,
  input logic [W-1:0] cap_i,
  input logic         irq_o
);
  localparam logic [W-1:0] ALL_ONES = '1;

  assert_stopped_cnt_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !(wr_en_i && addr_i == ADDR_CNT)) |=> $stable(cnt_i));

  assert_stopped_cap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(cap_i));

  assert_capture_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && edge_i && !(wr_en_i && addr_i == ADDR_CNT)) |=> (cnt_i <= W'(1)));

  assert_first_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && edge_i && first_i && !(tick_i && cnt_i == ALL_ONES)
     && !(wr_en_i && addr_i == ADDR_MODE)) |=> !irq_o);

  assert_wrap_sets_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && cnt_i == ALL_ONES) |=> (flag_i && irq_o));

  assert_flag_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_i && !run_i) |=> flag_i);

  assert_mode_irq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && wr_en_i && addr_i == ADDR_MODE && wdata_i[1:0] != mode_i) |=> irq_o);
endmodule

bind pulse_cap_timer pulse_cap_timer_chk #(.W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .tick_i  (cnt_en_i),
  .run_i   (run),
  .edge_i  (edge_valid),
  .first_i (first_pend),
  .flag_i  (flag),
  .mode_i  (mode),
  .cnt_i   (cnt),
  .cap_i   (cap),
  .irq_o   (irq_o)
);

// File: tb/pulse_cap_timer_test.sv
`timescale 1ns/1ps
module pulse_cap_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        pulse = 1'b0;
  logic        cnt_en = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  int irq_seen = 0;

  always #2.5 clk = ~clk;

  pulse_cap_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pulse_i(pulse),
    .cnt_en_i(cnt_en), .irq_o(irq)
  );

  always @(negedge clk) if (irq) irq_seen <= irq_seen + 1;

  typedef struct packed {
    logic [1:0]  mode;
    logic        end_high;
    logic [7:0]  th;
    logic [7:0]  tl;
    logic [15:0] cap;
    logic [7:0]  nirq;
  } vec_t;

  // mode, end high, high len, low len, expected capture, expected requests
  localparam vec_t VECS [6] = '{
    '{2'd0, 1'b0, 8'd4, 8'd6, 16'd10, 8'd2},
    '{2'd1, 1'b1, 8'd5, 8'd3, 16'd8,  8'd3},
    '{2'd1, 1'b0, 8'd7, 8'd9, 16'd16, 8'd2},
    '{2'd2, 1'b0, 8'd5, 8'd9, 16'd5,  8'd5},
    '{2'd2, 1'b1, 8'd6, 8'd4, 16'd4,  8'd6},
    '{2'd0, 1'b1, 8'd3, 8'd3, 16'd6,  8'd2}
  };

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int irq_since(input int base);
    return irq_seen - base;
  endfunction

  int base;
  logic [15:0] v;

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    check("R1 irq after reset", {15'd0, irq}, 16'd0);
    rd(2'd0, v); check("R1 mode/flag reset", v, 16'h0000);
    rd(2'd1, v); check("R1 run reset", v, 16'h0000);
    rd(2'd2, v); check("R1 counter reset", v, 16'h0000);
    rd(2'd3, v); check("R1 capture reset", v, 16'h0000);

    // R1 stopped: ticks and edges ignored
    #1 base = irq_seen;
    cnt_en = 1'b1;
    for (int k = 0; k < 4; k++) begin
      pulse = 1'b1; idle(3);
      pulse = 1'b0; idle(3);
    end
    idle(4);
    cnt_en = 1'b0;
    rd(2'd2, v); check("R1 counter held while stopped", v, 16'h0000);
    rd(2'd3, v); check("R1 capture held while stopped", v, 16'h0000);
    check("R1 no request while stopped", 16'(irq_since(base)), 16'd0);

    // R2 load, read back, tick counting
    wr(2'd2, 16'h1234);
    rd(2'd2, v); check("R2 counter load", v, 16'h1234);
    wr(2'd1, 16'h0001);
    idle(3);
    rd(2'd2, v); check("R2 no ticks no count", v, 16'h1234);
    @(negedge clk); cnt_en = 1'b1;
    idle(5);
    cnt_en = 1'b0;
    rd(2'd2, v); check("R2 five ticks", v, 16'h1239);
    wr(2'd1, 16'h0000);

    // R3 R4 R5 R6 table-driven measurement
    foreach (VECS[i]) begin
      wr(2'd1, 16'h0000);
      pulse = 1'b0; cnt_en = 1'b0;
      idle(5);
      wr(2'd2, 16'h0000);
      wr(2'd0, {14'd0, VECS[i].mode});
      #1 base = irq_seen;
      wr(2'd1, 16'h0001);
      cnt_en = 1'b1;
      for (int k = 0; k < 3; k++) begin
        pulse = 1'b1; idle(VECS[i].th);
        pulse = 1'b0; idle(VECS[i].tl);
      end
      if (VECS[i].end_high) pulse = 1'b1;
      idle(6);
      cnt_en = 1'b0;
      idle(1);
      rd(2'd3, v);
      check($sformatf("R3/R4 capture vec %0d", i), v, VECS[i].cap);
      check($sformatf("R5/R6 request count vec %0d", i), 16'(irq_since(base)), 16'(VECS[i].nirq));
      rd(2'd0, v);
      check($sformatf("R7 no wrap vec %0d", i), v, {14'd0, VECS[i].mode});
    end

    // R6 first capture loads but stays quiet
    wr(2'd1, 16'h0000);
    pulse = 1'b0; cnt_en = 1'b0;
    idle(5);
    wr(2'd2, 16'd100);
    wr(2'd0, 16'h0001);
    #1 base = irq_seen;
    wr(2'd1, 16'h0001);
    pulse = 1'b1; idle(5);
    rd(2'd3, v); check("R6 first capture value", v, 16'd100);
    check("R6 first capture silent", 16'(irq_since(base)), 16'd0);
    pulse = 1'b0; idle(5);
    pulse = 1'b1; idle(5);
    rd(2'd3, v); check("R3 second capture after restart", v, 16'd0);
    check("R5 second capture request", 16'(irq_since(base)), 16'd1);

    // R9 mode rewrites
    #1 base = irq_seen;
    wr(2'd0, 16'h0002); idle(2);
    check("R9 changed mode while running", 16'(irq_since(base)), 16'd1);
    #1 base = irq_seen;
    wr(2'd0, 16'h0002); idle(2);
    check("R9 same mode while running", 16'(irq_since(base)), 16'd0);
    wr(2'd1, 16'h0000);
    #1 base = irq_seen;
    wr(2'd0, 16'h0000); idle(2);
    check("R9 changed mode while stopped", 16'(irq_since(base)), 16'd0);

    // R7 R8 wrap flag
    pulse = 1'b0; idle(5);
    wr(2'd2, 16'hFFFF);
    wr(2'd1, 16'h0001);
    #1 base = irq_seen;
    @(negedge clk); cnt_en = 1'b1;
    @(negedge clk); cnt_en = 1'b0;
    idle(2);
    rd(2'd0, v); check("R7 flag set on wrap", v, 16'h0008);
    rd(2'd2, v); check("R7 counter wrapped", v, 16'h0000);
    check("R7 wrap request", 16'(irq_since(base)), 16'd1);
    wr(2'd0, 16'h0000);
    rd(2'd0, v); check("R8 no tick since wrap keeps flag", v, 16'h0008);
    @(negedge clk); cnt_en = 1'b1;
    @(negedge clk); cnt_en = 1'b0;
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h0000);
    rd(2'd0, v); check("R8 stopped write keeps flag", v, 16'h0008);
    wr(2'd1, 16'h0001);
    wr(2'd0, 16'h0000);
    rd(2'd0, v); check("R8 qualified write clears flag", v, 16'h0000);

    // R10 capture and wrap in one cycle
    wr(2'd1, 16'h0000);
    pulse = 1'b0; cnt_en = 1'b0; idle(5);
    wr(2'd0, 16'h0001);
    wr(2'd1, 16'h0001);
    pulse = 1'b1; idle(5);
    pulse = 1'b0; idle(5);
    wr(2'd2, 16'hFFFF);
    #1 base = irq_seen;
    @(negedge clk); pulse = 1'b1;
    @(negedge clk);
    @(negedge clk); cnt_en = 1'b1;
    @(negedge clk); cnt_en = 1'b0;
    idle(3);
    rd(2'd3, v); check("R10 capture of all ones", v, 16'hFFFF);
    rd(2'd0, v); check("R10 flag set with capture", v, 16'h0009);
    check("R10 single request", 16'(irq_since(base)), 16'd1);

    summary();
    $finish;
  end
endmodule